// File: doc/BRIEF.md
# Horizontal Sync Polarity Regenerator

This block sits beside the pixel data path of a video capture front end. It takes a raw horizontal sync line of unknown convention, sampled on the pixel clock, and works out for itself which level is the active one. It then produces a clean horizontal sync pulse of its own. The pulse has a programmable width in pixel clocks and a programmable active level. It is delayed by the same number of pixel clocks as the sampled pixel data, so downstream display logic sees sync and data in step.

Polarity is judged once per line. The block counts the cycles spent high and the cycles spent low between two consecutive rising edges of the sampled input. The shorter of the two is taken as the sync pulse. From then on, only the leading edge of that level starts an output pulse. Any further input transitions are ignored until the programmed width has run out.

Top module: `hsync_regen`

## Requirements
- R1: While reset is held, `sync_out` sits at its inactive level (the inverse of `out_active_high`) and `in_pol_high` reads 1.
- R2: When the input spends fewer cycles high than low over one line (rising edge to rising edge), `in_pol_high` becomes 1 after the second rising edge of that measurement.
- R3: When the input spends fewer cycles low than high over one line, `in_pol_high` becomes 0 after the rising edge that closes the line.
- R4: When high time and low time over a line are equal, the input is taken as active high (`in_pol_high` = 1).
- R5: `sync_out` is active at the level given by `out_active_high` (1 = active high, 0 = active low) and sits at the opposite level otherwise.
- R6: Each output pulse lasts exactly `pulse_width` pixel clocks for any non-zero value.
- R7: A `pulse_width` of 0 gives a pulse of one pixel clock.
- R8: The first active output cycle appears 7 pixel clocks after the input's leading edge is presented, which matches the pixel data latency.
- R9: Input edges that arrive while an output pulse is running neither restart it nor lengthen it.
- R10: The leading edge follows the detected polarity: a rising input edge when `in_pol_high` is 1, a falling input edge when it is 0.
- R11: Until one full line has been measured after reset, `in_pol_high` stays at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Raw horizontal sync, any polarity |
| out_active_high | input | 1 | 1: output pulse active high; 0: active low |
| pulse_width | input | WIDTH_W | Output pulse length in pixel clocks (0 acts as 1) |
| sync_out | output | 1 | Regenerated, latency-aligned horizontal sync |
| in_pol_high | output | 1 | Detected input polarity, 1 = active high |

## Verification
If the polarity decision is wrong, the output pulses start from the trailing edge of the input pulse rather than its leading edge. The first active output sample then moves from 7 clocks after the leading edge to 7 clocks after the trailing edge, and `in_pol_high` disagrees with the expected flag from the end of the second measured line. A wrong width counter or a pulse that restarts shows up within the same line as a wrong count of active output samples. A delay line of the wrong depth moves the first active sample off clock 7 straight away.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
   // Pixel path latency that the sync output has to match.
   localparam int HSR_PIXEL_LAT   = 7;
   // Register stages in front of the delay line: input sample plus pulse register.
   localparam int HSR_FRONT_STAGES = 2;

   typedef enum logic {
      HSR_POL_LOW  = 1'b0,
      HSR_POL_HIGH = 1'b1
   } hsr_pol_e;
endpackage

// File: rtl/hsr_edge_sampler.sv
module hsr_edge_sampler (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   output logic level,
   output logic rise,
   output logic fall
);
   logic       s_q;
   logic       s_qq;
   logic [1:0] hist_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_q      <= 1'b0;
         s_qq     <= 1'b0;
         hist_vld <= 2'b00;
      end else begin
         s_q      <= sync_in;
         s_qq     <= s_q;
         hist_vld <= {hist_vld[0], 1'b1};
      end
   end

   // Edges count only once both history stages hold real samples.
   assign level = s_q;
   assign rise  = hist_vld[1] &  s_q & ~s_qq;
   assign fall  = hist_vld[1] & ~s_q &  s_qq;
endmodule

// File: rtl/hsr_pol_detect.sv
module hsr_pol_detect
   import hsr_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   input  logic rise,
   output logic pol_high
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("hsr_pol_detect: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] hi_cnt;
   logic [CNT_W-1:0] lo_cnt;
   logic             seen_rise;
   logic             line_done;
   hsr_pol_e         pol_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_cnt    <= '0;
         lo_cnt    <= '0;
         seen_rise <= 1'b0;
         line_done <= 1'b0;
         pol_q     <= HSR_POL_HIGH;
      end else if (rise) begin
         if (seen_rise) begin
            // Shorter level is the sync pulse; a tie is read as active high.
            pol_q     <= (hi_cnt <= lo_cnt) ? HSR_POL_HIGH : HSR_POL_LOW;
            line_done <= 1'b1;
         end
         seen_rise <= 1'b1;
         hi_cnt    <= {{(CNT_W-1){1'b0}}, 1'b1};
         lo_cnt    <= '0;
      end else if (level) begin
         if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
      end else begin
         if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
      end
   end

   assign pol_high = (pol_q == HSR_POL_HIGH);

   AST_POL_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      !line_done |-> pol_high); // R11
   AST_POL_ONLY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pol_high) |-> $past(rise)); // R2
endmodule

// File: rtl/hsr_pulse_gen.sv
module hsr_pulse_gen #(
   parameter int WIDTH_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rise,
   input  logic               fall,
   input  logic               pol_high,
   input  logic [WIDTH_W-1:0] width,
   output logic               pulse
);
   generate
      if (WIDTH_W < 1) begin : g_bad_width
         $error("hsr_pulse_gen: WIDTH_W must be at least 1");
      end
   endgenerate

   logic [WIDTH_W-1:0] cnt_q;
   logic               pulse_q;
   logic               lead;
   logic [WIDTH_W-1:0] load_val;

   assign lead     = pol_high ? rise : fall;
   // Zero width behaves as one clock: load value is width-1, floored at 0.
   assign load_val = (width == '0) ? '0 : width - 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pulse_q <= 1'b0;
         cnt_q   <= '0;
      end else if (pulse_q) begin
         if (cnt_q == '0) pulse_q <= 1'b0;
         else             cnt_q   <= cnt_q - 1'b1;
      end else if (lead) begin
         pulse_q <= 1'b1;
         cnt_q   <= load_val;
      end
   end

   assign pulse = pulse_q;

   AST_START_ON_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_q) |-> $past(lead)); // R10
   AST_ZERO_WIDTH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pulse_q) && $past(width) == '0) |=> !pulse_q); // R7
   AST_END_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_q && cnt_q == '0) |=> !pulse_q); // R6
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_q && cnt_q != '0) |=> (pulse_q && cnt_q < $past(cnt_q))); // R9
endmodule

// File: rtl/hsr_delay_line.sv
module hsr_delay_line #(
   parameter int DEPTH = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (DEPTH < 0) begin : g_bad_depth
         $error("hsr_delay_line: DEPTH must not be negative");
      end else if (DEPTH == 0) begin : g_wire
         assign q = d;
      end else if (DEPTH == 1) begin : g_single
         logic stage_q;
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q <= 1'b0;
            else        stage_q <= d;
         end
         assign q = stage_q;
      end else begin : g_shift
         logic [DEPTH-1:0] sr_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sr_q <= '0;
            else        sr_q <= {sr_q[DEPTH-2:0], d};
         end
         assign q = sr_q[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/hsync_regen.sv
module hsync_regen
   import hsr_pkg::*;
#(
   parameter int WIDTH_W  = 8,
   parameter int CNT_W    = 12,
   parameter int PIPE_LAT = HSR_PIXEL_LAT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sync_in,
   input  logic               out_active_high,
   input  logic [WIDTH_W-1:0] pulse_width,
   output logic               sync_out,
   output logic               in_pol_high
);
   localparam int DLY_DEPTH = PIPE_LAT - HSR_FRONT_STAGES;

   generate
      if (PIPE_LAT < HSR_FRONT_STAGES) begin : g_bad_lat
         $error("hsync_regen: PIPE_LAT below the fixed front stages");
      end
   endgenerate

   logic lvl;
   logic rise;
   logic fall;
   logic pol_high;
   logic pulse;
   logic pulse_dly;

   hsr_edge_sampler u_sampler (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_in (sync_in),
      .level   (lvl),
      .rise    (rise),
      .fall    (fall)
   );

   hsr_pol_detect #(.CNT_W(CNT_W)) u_pol (
      .clk      (clk),
      .rst_n    (rst_n),
      .level    (lvl),
      .rise     (rise),
      .pol_high (pol_high)
   );

   hsr_pulse_gen #(.WIDTH_W(WIDTH_W)) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise     (rise),
      .fall     (fall),
      .pol_high (pol_high),
      .width    (pulse_width),
      .pulse    (pulse)
   );

   hsr_delay_line #(.DEPTH(DLY_DEPTH)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pulse),
      .q     (pulse_dly)
   );

   assign sync_out    = out_active_high ? pulse_dly : ~pulse_dly;
   assign in_pol_high = pol_high;

   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |=> (sync_out != out_active_high || !rst_n)); // R1
endmodule

// File: tb/hsync_regen_bench.sv
`timescale 1ns/1ps
module hsync_regen_bench;
   localparam int LINE = 64;
   localparam int LAT  = 7;
   localparam int NV   = 7;
   // Table: width, output active-high, input active-high, input pulse length,
   // expected polarity flag, expected active output cycles.
   localparam int V_W   [NV] = '{4, 4, 0, 1, 10,  3, 20};
   localparam int V_OH  [NV] = '{1, 0, 1, 0,  1,  1,  0};
   localparam int V_IH  [NV] = '{1, 1, 1, 0,  0,  1,  0};
   localparam int V_LEN [NV] = '{5, 5, 3, 6,  4, 12,  2};
   localparam int V_POL [NV] = '{1, 1, 1, 0,  0,  1,  0};
   localparam int V_CNT [NV] = '{4, 4, 1, 1, 10,  3, 20};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_in = 1'b0;
   logic       out_hi = 1'b1;
   logic [7:0] width = 8'd4;
   logic       sync_out;
   logic       pol;

   int tests = 0;
   int fails = 0;
   int first_i;
   int last_i;
   int act_n;

   always #4 clk = ~clk;

   hsync_regen u_hsync_regen (
      .clk             (clk),
      .rst_n           (rst_n),
      .sync_in         (sync_in),
      .out_active_high (out_hi),
      .pulse_width     (width),
      .sync_out        (sync_out),
      .in_pol_high     (pol)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic idle);
      rst_n   = 1'b0;
      sync_in = idle;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // One line: active level for alen cycles from index 0, optional second
   // burst of alen2 cycles at index at2; output sampled before each drive.
   task automatic run_line(input logic act_lvl, input int alen, input int at2, input int alen2);
      first_i = -1;
      last_i  = -1;
      act_n   = 0;
      for (int i = 0; i < LINE; i++) begin
         @(negedge clk);
         if (sync_out == out_hi) begin
            if (first_i < 0) first_i = i;
            last_i = i;
            act_n++;
         end
         sync_in = ((i < alen) || (at2 > 0 && i >= at2 && i < at2 + alen2)) ? act_lvl : ~act_lvl;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      // R1: reset state
      out_hi  = 1'b0;
      rst_n   = 1'b0;
      sync_in = 1'b1;
      repeat (3) @(negedge clk);
      check(sync_out == 1'b1, "R1 idle level active-low out", sync_out, 1);
      check(pol == 1'b1, "R1 polarity flag in reset", pol, 1);
      out_hi = 1'b1;
      @(negedge clk);
      check(sync_out == 1'b0, "R1 idle level active-high out", sync_out, 0);

      // Table walk: R2 R3 R5 R6 R7 R8 R10
      for (int v = 0; v < NV; v++) begin
         logic act;
         out_hi = V_OH[v][0];
         width  = 8'(V_W[v]);
         act    = V_IH[v][0];
         do_reset(~act);
         repeat (3) run_line(act, V_LEN[v], 0, 0);
         run_line(act, V_LEN[v], 0, 0);
         check(pol == V_POL[v][0], $sformatf("R2/R3 vec%0d polarity", v), pol, V_POL[v]);
         check(first_i == LAT, $sformatf("R8 R10 vec%0d first active index", v), first_i, LAT);
         check(act_n == V_CNT[v], $sformatf("R6 R7 vec%0d pulse length", v), act_n, V_CNT[v]);
         check(last_i - first_i + 1 == act_n, $sformatf("R5 vec%0d contiguous active level", v),
               last_i - first_i + 1, act_n);
      end

      // R4: tie after active-low detection (state left by last vector)
      repeat (3) run_line(1'b1, 32, 0, 0);
      check(pol == 1'b1, "R4 equal high and low time", pol, 1);

      // R9: second input pulse inside a running output pulse
      out_hi = 1'b1;
      width  = 8'd12;
      do_reset(1'b0);
      repeat (3) run_line(1'b1, 2, 5, 2);
      run_line(1'b1, 2, 5, 2);
      check(act_n == 12, "R9 retrigger ignored length", act_n, 12);
      check(first_i == LAT, "R9 retrigger ignored start", first_i, LAT);

      // R11: default before a full line, then active-low decision
      out_hi = 1'b1;
      width  = 8'd4;
      do_reset(1'b1);
      run_line(1'b0, 6, 0, 0);
      check(pol == 1'b1, "R11 flag before full line", pol, 1);
      run_line(1'b0, 6, 0, 0);
      check(pol == 1'b0, "R3 flag after full line", pol, 0);

      // R7: zero width with active-low output
      out_hi = 1'b0;
      width  = 8'd0;
      run_line(1'b0, 6, 0, 0);
      run_line(1'b0, 6, 0, 0);
      check(act_n == 1, "R7 zero width one clock", act_n, 1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule